// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sits between a buck controller's three-level PWM command and the two gate drivers of a synchronous buck power stage. It produces a high-side gate enable and a low-side gate enable. Each edge it drives is break-before-make: a gate is released, the bench or board reports through a feedback input that the gate has actually discharged, and only after a further programmable dead time may the opposite gate turn on.

The middle PWM level selects a diode-emulation mode. The high-side gate stays off. After the dead time the low-side gate turns on and is held on through a blanking window and a debounce window. After both windows the block watches a zero-current comparator input. When that input reports that the inductor current has reached zero, the low-side gate is released and both gates stay off until the command leaves the middle level.

An enable input and a supply-good input both force the gates off. While supply-good is low, the block also raises a pull-down request for the shared enable line, so that the upstream controller can see the undervoltage fault. All seven inputs are asynchronous and pass through a synchronizer chain. All outputs come straight from flops.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is asserted, both gate enables are low and the enable-line pull-down request is high.
- R2: The PWM command is a 2-bit code: 2'b00 is low, 2'b01 is mid and 2'b10 is high. With enable and supply-good both high, a steady high command leaves only the high-side gate on, and a steady low command leaves only the low-side gate on.
- R3: On a move to a high command, the low-side gate turns off first. The high-side gate turns on only after the low-side feedback has reported "discharged" and at least NOVL_CYC further cycles have passed. If that feedback never reports, the high-side gate stays off.
- R4: On a move to a low command, the high-side gate turns off first. The low-side gate turns on only after the high-side feedback has reported "discharged" and at least NOVL_CYC further cycles have passed.
- R5: The two gate enables are never high in the same cycle.
- R6: In the mid level the high-side gate is off. After the dead time the low-side gate is on, and it stays on for at least BLANK_CYC + DEB_CYC cycles whatever the zero-current input does. It also stays on afterwards for as long as no zero current is reported.
- R7: In the mid level, once both timers have expired and the zero-current input is high, the low-side gate turns off. It then stays off for the rest of that mid period, even if the zero-current input toggles.
- R8: The reserved code 2'b11 behaves exactly like the mid level.
- R9: A high or low command clears the zero-current latch-off. A later return to the mid level turns the low-side gate on again and restarts blanking.
- R10: While enable is low, both gates are off regardless of the command. When enable returns, sequencing resumes from the both-off state.
- R11: While supply-good is low, both gates are off and the pull-down request is high. When supply-good returns, the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 2 | Three-level PWM command code (asynchronous) |
| en_in | input | 1 | Driver enable (asynchronous) |
| supply_ok | input | 1 | Supply above undervoltage threshold (asynchronous) |
| zc_det | input | 1 | Zero inductor current reported (asynchronous) |
| hs_fb_low | input | 1 | High-side gate-to-switch voltage below threshold |
| ls_fb_low | input | 1 | Low-side gate voltage below threshold |
| hs_gate | output | 1 | High-side gate enable, registered |
| ls_gate | output | 1 | Low-side gate enable, registered |
| en_pull | output | 1 | Request to pull the shared enable line low (fault) |

## Verification
The following are checked on every cycle:
- the two gates are never on together;
- every high-side or low-side turn-on follows at least NOVL_CYC cycles with the opposite gate off;
- the high-side gate is on only under a high command;
- gates fall within one cycle of a synchronized enable or supply-good loss;
- a mid-level low-side release is always preceded by a zero-current report.

The following only the bench's scenarios can show:
- a stuck feedback input holds the high-side gate off indefinitely;
- the blanking and debounce windows mask an early zero-current report;
- the latch-off persists through zero-current toggling;
- the reserved code matches mid;
- a pass through low re-arms diode emulation.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  // Command codes as they arrive on pwm_cmd
  localparam logic [1:0] PWM_CODE_LO  = 2'b00;
  localparam logic [1:0] PWM_CODE_MID = 2'b01;
  localparam logic [1:0] PWM_CODE_HI  = 2'b10;

  // One-hot decoded level: bit 0 low, bit 1 mid, bit 2 high
  typedef logic [2:0] lvl_oh_t;

  typedef enum logic [3:0] {
    ST_IDLE,      // both off, nothing in progress
    ST_WAIT_LS,   // low side released, waiting for its discharge report
    ST_NOVL_HS,   // dead time before high side
    ST_HS_ON,
    ST_WAIT_HS,   // high side released, waiting for its discharge report
    ST_NOVL_LS,   // dead time before low side
    ST_LS_ON,
    ST_BLANK,     // mid: low side on, zero-current masked
    ST_DEBOUNCE,  // mid: low side on, still masked
    ST_ZC_WATCH,  // mid: low side on, watching zero-current
    ST_DE_OFF     // mid: zero current seen, both off
  } gate_state_e;

  function automatic lvl_oh_t decode_level(input logic [1:0] code);
    lvl_oh_t r;
    case (code)
      PWM_CODE_LO: r = 3'b001;
      PWM_CODE_HI: r = 3'b100;
      default:     r = 3'b010;  // mid and the reserved code
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bgs_timer.sv
module bgs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  // A load of N makes zero true on the Nth cycle after the load edge
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val - CNT_W'(1);
    else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/bgs_fsm.sv
module bgs_fsm
  import buck_gate_pkg::*;
#(
  parameter int NOVL_CYC  = 4,
  parameter int BLANK_CYC = 50,
  parameter int DEB_CYC   = 16,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  lvl_oh_t          lvl,
  input  logic             hs_fb,
  input  logic             ls_fb,
  input  logic             zc,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             hs_gate,
  output logic             ls_gate
);

  localparam logic [CNT_W-1:0] NOVL_V  = CNT_W'(NOVL_CYC);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] DEB_V   = CNT_W'(DEB_CYC);

  gate_state_e state, nxt;
  logic is_lo, is_mid, is_hi;

  assign is_lo  = lvl[0];
  assign is_mid = lvl[1];
  assign is_hi  = lvl[2];

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = NOVL_V;
    if (!run) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: nxt = is_hi ? ST_WAIT_LS : ST_WAIT_HS;
        ST_WAIT_LS: begin
          if (!is_hi) nxt = ST_WAIT_HS;
          else if (ls_fb) begin
            nxt = ST_NOVL_HS; tmr_load = 1'b1; tmr_val = NOVL_V;
          end
        end
        ST_NOVL_HS: begin
          if (!is_hi)        nxt = ST_WAIT_HS;
          else if (tmr_zero) nxt = ST_HS_ON;
        end
        ST_HS_ON: if (!is_hi) nxt = ST_WAIT_HS;
        ST_WAIT_HS: begin
          if (is_hi) nxt = ST_WAIT_LS;
          else if (hs_fb) begin
            nxt = ST_NOVL_LS; tmr_load = 1'b1; tmr_val = NOVL_V;
          end
        end
        ST_NOVL_LS: begin
          if (is_hi) nxt = ST_WAIT_LS;
          else if (tmr_zero) begin
            if (is_lo) nxt = ST_LS_ON;
            else begin
              nxt = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
            end
          end
        end
        ST_LS_ON: begin
          if (is_hi) nxt = ST_WAIT_LS;
          else if (is_mid) begin
            nxt = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
          end
        end
        ST_BLANK: begin
          if (is_hi)      nxt = ST_WAIT_LS;
          else if (is_lo) nxt = ST_LS_ON;
          else if (tmr_zero) begin
            nxt = ST_DEBOUNCE; tmr_load = 1'b1; tmr_val = DEB_V;
          end
        end
        ST_DEBOUNCE: begin
          if (is_hi)         nxt = ST_WAIT_LS;
          else if (is_lo)    nxt = ST_LS_ON;
          else if (tmr_zero) nxt = ST_ZC_WATCH;
        end
        ST_ZC_WATCH: begin
          if (is_hi)      nxt = ST_WAIT_LS;
          else if (is_lo) nxt = ST_LS_ON;
          else if (zc)    nxt = ST_DE_OFF;
        end
        ST_DE_OFF: begin
          if (is_hi)      nxt = ST_WAIT_LS;
          else if (is_lo) nxt = ST_WAIT_HS;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      state   <= nxt;
      hs_gate <= (nxt == ST_HS_ON);
      ls_gate <= (nxt == ST_LS_ON) || (nxt == ST_BLANK) ||
                 (nxt == ST_DEBOUNCE) || (nxt == ST_ZC_WATCH);
    end
  end

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int NOVL_CYC    = 4,
  parameter int BLANK_CYC   = 50,
  parameter int DEB_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwm_cmd,
  input  logic       en_in,
  input  logic       supply_ok,
  input  logic       zc_det,
  input  logic       hs_fb_low,
  input  logic       ls_fb_low,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic       en_pull
);

  localparam int MAX_A   = (NOVL_CYC > BLANK_CYC) ? NOVL_CYC : BLANK_CYC;
  localparam int MAX_CYC = (MAX_A > DEB_CYC) ? MAX_A : DEB_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IN_W    = 7;

  logic [IN_W-1:0] raw_in, sync_in;
  logic [1:0]      pwm_s;
  logic            en_s, pg_s, zc_s, hs_fb_s, ls_fb_s;
  lvl_oh_t         lvl_oh;
  logic            run_s;
  logic            tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  assign raw_in = {pwm_cmd, en_in, supply_ok, zc_det, hs_fb_low, ls_fb_low};

  bgs_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign {pwm_s, en_s, pg_s, zc_s, hs_fb_s, ls_fb_s} = sync_in;
  assign lvl_oh = decode_level(pwm_s);
  assign run_s  = en_s & pg_s;

  bgs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  bgs_fsm #(
    .NOVL_CYC  (NOVL_CYC),
    .BLANK_CYC (BLANK_CYC),
    .DEB_CYC   (DEB_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .run      (run_s),
    .lvl      (lvl_oh),
    .hs_fb    (hs_fb_s),
    .ls_fb    (ls_fb_s),
    .zc       (zc_s),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .hs_gate  (hs_gate),
    .ls_gate  (ls_gate)
  );

  // Fault request held until the supply is seen good through the synchronizer
  always_ff @(posedge clk) begin
    if (rst) en_pull <= 1'b1;
    else     en_pull <= ~pg_s;
  end

endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
  parameter int NOVL_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       hs_gate,
  input logic       ls_gate,
  input logic       en_pull,
  input logic       en_s,
  input logic       pg_s,
  input logic       zc_s,
  input logic [2:0] lvl_oh
);

  localparam int OC_W = $clog2(NOVL_CYC + 1) + 1;

  logic [OC_W-1:0] ls_off_cnt, hs_off_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_off_cnt <= '0;
      hs_off_cnt <= '0;
    end else begin
      if (ls_gate)                          ls_off_cnt <= '0;
      else if (ls_off_cnt < OC_W'(NOVL_CYC)) ls_off_cnt <= ls_off_cnt + OC_W'(1);
      if (hs_gate)                          hs_off_cnt <= '0;
      else if (hs_off_cnt < OC_W'(NOVL_CYC)) hs_off_cnt <= hs_off_cnt + OC_W'(1);
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate && en_pull));

  assert_hs_only_high_R2: assert property (@(posedge clk) disable iff (rst)
    hs_gate |-> $past(lvl_oh[2]));

  assert_hs_dead_time_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> (ls_off_cnt >= OC_W'(NOVL_CYC)));

  assert_ls_dead_time_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> (hs_off_cnt >= OC_W'(NOVL_CYC)));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  assert_zc_release_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(ls_gate) && $past(en_s && pg_s) && $past(lvl_oh[1])) |-> $past(zc_s));

  assert_disable_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (!hs_gate && !ls_gate));

  assert_uv_fault_R11: assert property (@(posedge clk) disable iff (rst)
    !pg_s |=> (!hs_gate && !ls_gate && en_pull));

endmodule

bind buck_gate_seq buck_gate_seq_chk #(.NOVL_CYC(NOVL_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hs_gate (hs_gate),
  .ls_gate (ls_gate),
  .en_pull (en_pull),
  .en_s    (en_s),
  .pg_s    (pg_s),
  .zc_s    (zc_s),
  .lvl_oh  (lvl_oh)
);

// File: tb/buck_gate_seq_tb.sv
`timescale 1ns/1ps
module buck_gate_seq_tb;

  localparam int NOVL  = 4;
  localparam int BLANK = 50;
  localparam int DEB   = 16;

  typedef struct {
    logic [2:0] val;   // {hs, ls, pull}
    int         gap;   // minimum cycles since previous output change
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pwm = 2'b00;
  logic en = 1'b0, pg = 1'b1, zc = 1'b0, ls_stuck = 1'b0;
  logic hs_gate, ls_gate, en_pull;
  logic hs_fb, ls_fb;

  int n_chk = 0, n_fail = 0, cyc = 0, last_cyc = 0;
  bit mon_on = 1'b0;
  logic [2:0] prev = 3'b001;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Feedback model: a gate reads as discharged as soon as its enable drops
  assign hs_fb = ~hs_gate;
  assign ls_fb = ~ls_gate & ~ls_stuck;

  buck_gate_seq #(.NOVL_CYC(NOVL), .BLANK_CYC(BLANK), .DEB_CYC(DEB), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pwm_cmd(pwm), .en_in(en), .supply_ok(pg), .zc_det(zc),
    .hs_fb_low(hs_fb), .ls_fb_low(ls_fb),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .en_pull(en_pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] v, input int gap, input string tag);
    exp_t e;
    e.val = v; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // Monitor: every output change must match the next expected item
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && ({hs_gate, ls_gate, en_pull} != prev)) begin
        if (q.size() == 0) begin
          chk(1'b0, "unexpected output change", int'({hs_gate, ls_gate, en_pull}), int'(prev));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({hs_gate, ls_gate, en_pull} == e.val, e.tag,
              int'({hs_gate, ls_gate, en_pull}), int'(e.val));
          chk((cyc - last_cyc) >= e.gap, {e.tag, " spacing"}, cyc - last_cyc, e.gap);
        end
        prev = {hs_gate, ls_gate, en_pull};
        last_cyc = cyc;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({hs_gate, ls_gate, en_pull} == 3'b001, "R1 reset state",
        int'({hs_gate, ls_gate, en_pull}), 1);
    last_cyc = cyc;
    mon_on = 1'b1;
    push(3'b000, 0, "R11 pull released with supply good");
    rst = 1'b0;
    settle();

    // R10: enable low blocks a high command
    pwm = 2'b10;
    repeat (30) @(negedge clk);
    chk(!hs_gate && !ls_gate, "R10 disabled gates off", int'({hs_gate, ls_gate}), 0);
    pwm = 2'b00;
    push(3'b010, NOVL, "R2 low command low side on");
    en = 1'b1;
    settle();
    chk(ls_gate && !hs_gate, "R2 steady low", int'({hs_gate, ls_gate}), 1);

    // R3: low to high
    push(3'b000, 0, "R3 low side off first");
    push(3'b100, NOVL, "R3 high side after dead time");
    pwm = 2'b10;
    settle();
    chk(hs_gate && !ls_gate, "R2 steady high", int'({hs_gate, ls_gate}), 2);

    // R4: high to low
    push(3'b000, 0, "R4 high side off first");
    push(3'b010, NOVL, "R4 low side after dead time");
    pwm = 2'b00;
    settle();

    push(3'b000, 0, "R3 low side off first");
    push(3'b100, NOVL, "R3 high side after dead time");
    pwm = 2'b10;
    settle();

    // R6/R7: mid with zero current already reported, must be masked
    zc = 1'b1;
    push(3'b000, 0, "R6 high side off in mid");
    push(3'b010, NOVL, "R6 low side on after dead time");
    push(3'b000, BLANK + DEB, "R6 blanking masks zero current");
    pwm = 2'b01;
    settle();
    zc = 1'b0;
    repeat (40) @(negedge clk);
    zc = 1'b1;
    repeat (40) @(negedge clk);
    chk(!ls_gate && !hs_gate, "R7 latch-off holds", int'({hs_gate, ls_gate}), 0);

    // R9: low clears latch-off; R6: no release without zero current
    zc = 1'b0;
    push(3'b010, NOVL, "R9 low re-enables low side");
    pwm = 2'b00;
    settle();
    pwm = 2'b01;
    repeat (BLANK + DEB + 60) @(negedge clk);
    chk(ls_gate, "R6 low side held without zero current", int'(ls_gate), 1);
    push(3'b000, BLANK + DEB, "R7 release on zero current");
    zc = 1'b1;
    settle();

    push(3'b010, NOVL, "R9 low after latch-off");
    pwm = 2'b00;
    settle();
    push(3'b000, BLANK + DEB, "R9 blanking restarts");
    pwm = 2'b01;
    settle();

    // R8: reserved code acts as mid
    push(3'b100, NOVL, "R8 setup high");
    pwm = 2'b10;
    settle();
    push(3'b000, 0, "R8 high side off");
    push(3'b010, NOVL, "R8 low side on");
    push(3'b000, BLANK + DEB, "R8 zero-current release");
    pwm = 2'b11;
    settle();

    // R3: stuck low-side feedback blocks the high side
    push(3'b010, NOVL, "R3 setup low");
    pwm = 2'b00;
    settle();
    ls_stuck = 1'b1;
    push(3'b000, 0, "R3 low side off");
    pwm = 2'b10;
    settle();
    repeat (100) @(negedge clk);
    chk(!hs_gate, "R3 stuck feedback holds high side off", int'(hs_gate), 0);
    push(3'b100, NOVL, "R3 high side after feedback");
    ls_stuck = 1'b0;
    settle();

    // R10: enable drop while high side is on
    push(3'b000, 0, "R10 enable low forces off");
    en = 1'b0;
    settle();
    chk(!hs_gate && !ls_gate, "R10 off while disabled", int'({hs_gate, ls_gate}), 0);
    push(3'b100, NOVL, "R10 resume");
    en = 1'b1;
    settle();

    // R11: undervoltage
    push(3'b001, 0, "R11 undervoltage fault");
    pg = 1'b0;
    settle();
    chk(en_pull && !hs_gate && !ls_gate, "R11 fault held",
        int'({hs_gate, ls_gate, en_pull}), 1);
    push(3'b000, 0, "R11 fault cleared");
    push(3'b100, NOVL, "R11 resume high");
    pg = 1'b1;
    settle();

    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    summary();
    $finish;
  end

endmodule